// File: doc/BRIEF.md
# Deferred-Softmax Row Reducer and Normalizer

This block is the back end of a windowed attention row. A bank of `NSLOT` compute cores hands over, for one query row, an `H`-element weighted slice per core together with one unnormalised weight per core. The block adds the slices element by element into a single output vector. In the same pass it adds the weights into a row denominator. It then divides every vector element by that denominator and streams the normalised vector out one element at a time.

Both sums run in two sub-stages. The first sub-stage splits the cores into groups of `GROUP`. Each group runs its own set of `H` accumulators and spends one cycle per core in the group. The second sub-stage folds the group partials into the final vector and denominator, spending one cycle per group. Valid/ready handshakes sit between the sub-stages. A new row can therefore enter the first sub-stage while the previous row is still being combined or divided. All arithmetic is unsigned integer, and the quotient is truncated.

Top module: `attn_row_normalizer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_zero_den` is 0.
- R2: Output element e equals floor(Σ_s slice[s][e] / Σ_s weight[s]) for a non-zero denominator. Slot s, element e of `in_slices` sits at bits `(s*H+e)*DW +: DW`, and weight s of `in_weights` sits at bits `s*WW +: WW`.
- R3: A row's elements leave in index order 0 to H-1, and `out_last` is 1 on element H-1 only.
- R4: `out_valid` is never high on two consecutive cycles. Within a row, successive elements are exactly 2 cycles apart.
- R5: A row whose weights sum to zero produces H elements of value 0 and sets `err_zero_den`.
- R6: Once set, `err_zero_den` stays 1 through later valid rows until reset.
- R7: `in_ready` falls on the cycle after an acceptance. Changes on `in_slices` and `in_weights` while no row is being accepted do not change any result.
- R8: When two rows are offered back to back into an empty block, the second is accepted before the first row's first output element appears.
- R9: Into an empty block, the first output element is valid GROUP + NSLOT/GROUP + 3 clock edges after the edge that accepts the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row of slices and weights is offered |
| in_ready | output | 1 | First sub-stage can take a row |
| in_slices | input | NSLOT*H*DW | Per-core weighted slices, flattened |
| in_weights | input | NSLOT*WW | Per-core unnormalised weights, flattened |
| out_valid | output | 1 | `out_data` holds a normalised element |
| out_data | output | AW | Normalised element, AW = DW+log2(GROUP)+log2(NSLOT/GROUP) |
| out_last | output | 1 | Marks element H-1 of a row |
| err_zero_den | output | 1 | Sticky flag: some row had a zero denominator |

## Verification
Assertions check the following on every cycle:
- no two consecutive output strobes;
- `out_last` never appears without `out_valid`;
- the error flag is sticky;
- a zero denominator at the divider hand-off raises the flag;
- the first sub-stage blocks input immediately after each acceptance;
- the partials held at each stalled hand-off do not change.

Only the bench scenarios can show:
- the numeric result of each row against sums computed independently;
- element order and the last marker;
- the fixed latency of an isolated row;
- the overlap of two back-to-back rows;
- that wiggling idle inputs leaves results untouched.

// File: rtl/arn_pkg.sv
package arn_pkg;
  typedef enum logic [1:0] {
    ARN_IDLE = 2'd0,
    ARN_RUN  = 2'd1,
    ARN_HOLD = 2'd2
  } arn_state_e;
endpackage

// File: rtl/arn_group_acc.sv
// First sub-stage: per-group accumulation of slices and weights.
module arn_group_acc
  import arn_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int H     = 4,
  parameter int GROUP = 4,
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int PAW   = DW + $clog2(GROUP),
  parameter int PWW   = WW + $clog2(GROUP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NSLOT*H*DW-1:0]     in_slices,
  input  logic [NSLOT*WW-1:0]       in_weights,
  output logic                      p_valid,
  input  logic                      p_ready,
  output logic [(NSLOT/GROUP)*H*PAW-1:0] p_data,
  output logic [(NSLOT/GROUP)*PWW-1:0]   p_wdata
);
  localparam int NGRP = NSLOT / GROUP;
  localparam int CW   = (GROUP > 1) ? $clog2(GROUP) : 1;

  arn_state_e               st;
  logic [CW-1:0]            cnt;
  logic [NSLOT*H*DW-1:0]    slc_q;
  logic [NSLOT*WW-1:0]      wt_q;
  logic [NGRP*H*PAW-1:0]    part_q;
  logic [NGRP*PWW-1:0]      wpart_q;

  assign in_ready = (st == ARN_IDLE);
  assign p_valid  = (st == ARN_HOLD);
  assign p_data   = part_q;
  assign p_wdata  = wpart_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ARN_IDLE;
      cnt     <= '0;
      slc_q   <= '0;
      wt_q    <= '0;
      part_q  <= '0;
      wpart_q <= '0;
    end else begin
      case (st)
        ARN_IDLE: begin
          if (in_valid) begin
            slc_q   <= in_slices;
            wt_q    <= in_weights;
            part_q  <= '0;
            wpart_q <= '0;
            cnt     <= '0;
            st      <= ARN_RUN;
          end
        end
        ARN_RUN: begin
          for (int g = 0; g < NGRP; g++) begin
            for (int e = 0; e < H; e++) begin
              part_q[(g*H+e)*PAW +: PAW] <= part_q[(g*H+e)*PAW +: PAW]
                + PAW'(slc_q[((g*GROUP + int'(cnt))*H + e)*DW +: DW]);
            end
            wpart_q[g*PWW +: PWW] <= wpart_q[g*PWW +: PWW]
              + PWW'(wt_q[(g*GROUP + int'(cnt))*WW +: WW]);
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(GROUP-1)) st <= ARN_HOLD;
        end
        ARN_HOLD: begin
          if (p_ready) st <= ARN_IDLE;
        end
        default: st <= ARN_IDLE;
      endcase
    end
  end

  // R7
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  part_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (p_valid && !p_ready) |=> (p_valid && $stable(p_data) && $stable(p_wdata)));
endmodule

// File: rtl/arn_group_combine.sv
// Second sub-stage: fold group partials into the row vector and denominator.
module arn_group_combine
  import arn_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int H    = 4,
  parameter int PAW  = 10,
  parameter int PWW  = 10,
  parameter int AW   = PAW + $clog2(NGRP),
  parameter int DENW = PWW + $clog2(NGRP)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  p_valid,
  output logic                  p_ready,
  input  logic [NGRP*H*PAW-1:0] p_data,
  input  logic [NGRP*PWW-1:0]   p_wdata,
  output logic                  v_valid,
  input  logic                  v_ready,
  output logic [H*AW-1:0]       v_data,
  output logic [DENW-1:0]       v_den
);
  localparam int CW = (NGRP > 1) ? $clog2(NGRP) : 1;

  arn_state_e             st;
  logic [CW-1:0]          cnt;
  logic [NGRP*H*PAW-1:0]  part_q;
  logic [NGRP*PWW-1:0]    wpart_q;
  logic [H*AW-1:0]        sum_q;
  logic [DENW-1:0]        den_q;

  assign p_ready = (st == ARN_IDLE);
  assign v_valid = (st == ARN_HOLD);
  assign v_data  = sum_q;
  assign v_den   = den_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ARN_IDLE;
      cnt     <= '0;
      part_q  <= '0;
      wpart_q <= '0;
      sum_q   <= '0;
      den_q   <= '0;
    end else begin
      case (st)
        ARN_IDLE: begin
          if (p_valid) begin
            part_q  <= p_data;
            wpart_q <= p_wdata;
            sum_q   <= '0;
            den_q   <= '0;
            cnt     <= '0;
            st      <= ARN_RUN;
          end
        end
        ARN_RUN: begin
          for (int e = 0; e < H; e++) begin
            sum_q[e*AW +: AW] <= sum_q[e*AW +: AW]
              + AW'(part_q[(int'(cnt)*H + e)*PAW +: PAW]);
          end
          den_q <= den_q + DENW'(wpart_q[int'(cnt)*PWW +: PWW]);
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(NGRP-1)) st <= ARN_HOLD;
        end
        ARN_HOLD: begin
          if (v_ready) st <= ARN_IDLE;
        end
        default: st <= ARN_IDLE;
      endcase
    end
  end

  // R2
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (v_valid && !v_ready) |=> (v_valid && $stable(v_data) && $stable(v_den)));
endmodule

// File: rtl/arn_row_divider.sv
// Output stage: one quotient every two cycles, zero-denominator guard.
module arn_row_divider
  import arn_pkg::*;
#(
  parameter int H    = 4,
  parameter int AW   = 11,
  parameter int DENW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_valid,
  output logic             v_ready,
  input  logic [H*AW-1:0]  v_data,
  input  logic [DENW-1:0]  v_den,
  output logic             out_valid,
  output logic [AW-1:0]    out_data,
  output logic             out_last,
  output logic             err_zero_den
);
  localparam int IW = (H > 1) ? $clog2(H) : 1;

  arn_state_e        st;
  logic [IW-1:0]     idx;
  logic              ph;
  logic [H*AW-1:0]   num_q;
  logic [DENW-1:0]   den_q;
  logic [AW-1:0]     num_sel;
  logic [AW-1:0]     quot;

  assign v_ready = (st == ARN_IDLE);

  always_comb begin
    num_sel = num_q[int'(idx)*AW +: AW];
    quot    = (den_q == '0) ? '0 : AW'(num_sel / den_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ARN_IDLE;
      idx          <= '0;
      ph           <= 1'b0;
      num_q        <= '0;
      den_q        <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_last     <= 1'b0;
      err_zero_den <= 1'b0;
    end else begin
      case (st)
        ARN_IDLE: begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (v_valid) begin
            num_q <= v_data;
            den_q <= v_den;
            idx   <= '0;
            ph    <= 1'b0;
            st    <= ARN_RUN;
            if (v_den == '0) err_zero_den <= 1'b1;
          end
        end
        ARN_RUN: begin
          if (!ph) begin
            out_valid <= 1'b1;
            out_data  <= quot;
            out_last  <= (idx == IW'(H-1));
            ph        <= 1'b1;
          end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            ph        <= 1'b0;
            if (idx == IW'(H-1)) st <= ARN_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        default: st <= ARN_IDLE;
      endcase
    end
  end

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_zero_den |=> err_zero_den);

  // R5
  zero_den_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (v_valid && v_ready && v_den == '0) |=> err_zero_den);
endmodule

// File: rtl/attn_row_normalizer.sv
module attn_row_normalizer #(
  parameter int NSLOT = 8,
  parameter int H     = 4,
  parameter int GROUP = 4,
  parameter int DW    = 8,
  parameter int WW    = 8,
  localparam int NGRP = NSLOT / GROUP,
  localparam int PAW  = DW + $clog2(GROUP),
  localparam int PWW  = WW + $clog2(GROUP),
  localparam int AW   = PAW + $clog2(NGRP),
  localparam int DENW = PWW + $clog2(NGRP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NSLOT*H*DW-1:0]  in_slices,
  input  logic [NSLOT*WW-1:0]    in_weights,
  output logic                   out_valid,
  output logic [AW-1:0]          out_data,
  output logic                   out_last,
  output logic                   err_zero_den
);
  logic                  p_valid, p_ready;
  logic [NGRP*H*PAW-1:0] p_data;
  logic [NGRP*PWW-1:0]   p_wdata;
  logic                  v_valid, v_ready;
  logic [H*AW-1:0]       v_data;
  logic [DENW-1:0]       v_den;

  arn_group_acc #(
    .NSLOT(NSLOT), .H(H), .GROUP(GROUP), .DW(DW), .WW(WW),
    .PAW(PAW), .PWW(PWW)
  ) u_acc (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_slices(in_slices), .in_weights(in_weights),
    .p_valid(p_valid), .p_ready(p_ready),
    .p_data(p_data), .p_wdata(p_wdata)
  );

  arn_group_combine #(
    .NGRP(NGRP), .H(H), .PAW(PAW), .PWW(PWW), .AW(AW), .DENW(DENW)
  ) u_comb (
    .clk(clk), .rst(rst),
    .p_valid(p_valid), .p_ready(p_ready),
    .p_data(p_data), .p_wdata(p_wdata),
    .v_valid(v_valid), .v_ready(v_ready),
    .v_data(v_data), .v_den(v_den)
  );

  arn_row_divider #(
    .H(H), .AW(AW), .DENW(DENW)
  ) u_div (
    .clk(clk), .rst(rst),
    .v_valid(v_valid), .v_ready(v_ready),
    .v_data(v_data), .v_den(v_den),
    .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .err_zero_den(err_zero_den)
  );
endmodule

// File: tb/tb_attn_row_normalizer.sv
`timescale 1ns/1ps
module tb_attn_row_normalizer;
  localparam int NSLOT = 8;
  localparam int H     = 4;
  localparam int GROUP = 4;
  localparam int DW    = 8;
  localparam int WW    = 8;
  localparam int AW    = DW + $clog2(NSLOT);
  localparam int LAT   = GROUP + NSLOT/GROUP + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NSLOT*H*DW-1:0] in_slices = '0;
  logic [NSLOT*WW-1:0]   in_weights = '0;
  logic out_valid, out_last, err_zero_den;
  logic [AW-1:0] out_data;

  always #2 clk = ~clk;

  attn_row_normalizer #(.NSLOT(NSLOT), .H(H), .GROUP(GROUP), .DW(DW), .WW(WW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_slices(in_slices), .in_weights(in_weights),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .err_zero_den(err_zero_den)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  int exp_q[$];
  int acc_q[$];
  bit lat_q[$];
  int mon_e = 0;
  int row_acc = 0;
  bit row_lat = 0;
  bit prev_ov = 0;
  int prev_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic send_row(input logic [NSLOT*H*DW-1:0] s, input logic [NSLOT*WW-1:0] w,
                          input bit lat, output int acc);
    int den;
    den = 0;
    for (int k = 0; k < NSLOT; k++) den += int'(w[k*WW +: WW]);
    @(negedge clk);
    in_slices  = s;
    in_weights = w;
    in_valid   = 1'b1;
    while (!in_ready) @(negedge clk);
    acc = cyc + 1;
    for (int e = 0; e < H; e++) begin
      int num;
      num = 0;
      for (int k = 0; k < NSLOT; k++) num += int'(s[(k*H+e)*DW +: DW]);
      exp_q.push_back((den == 0) ? 0 : num / den);
    end
    acc_q.push_back(acc);
    lat_q.push_back(lat);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((exp_q.size() != 0 || in_ready == 1'b0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        // R4
        chk(!prev_ov, "R4 back-to-back strobe", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected output", int'(out_data), -1);
        end else begin
          int ev;
          ev = exp_q.pop_front();
          if (mon_e == 0) begin
            row_acc = acc_q.pop_front();
            row_lat = lat_q.pop_front();
            // R9
            if (row_lat) chk(cyc - row_acc == LAT, "R9 latency", cyc - row_acc, LAT);
          end else begin
            // R4
            chk(cyc - prev_cyc == 2, "R4 element spacing", cyc - prev_cyc, 2);
          end
          // R2
          chk(int'(out_data) == ev, "R2 element value", int'(out_data), ev);
          // R3
          chk(out_last == (mon_e == H-1), "R3 last flag", int'(out_last), int'(mon_e == H-1));
          prev_cyc = cyc;
          mon_e = (mon_e == H-1) ? 0 : mon_e + 1;
        end
      end
      prev_ov = out_valid;
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NSLOT*H*DW-1:0] s;
    logic [NSLOT*WW-1:0]   w;
    int acc_a, acc_b, dummy;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(err_zero_den == 1'b0, "R1 err after reset", int'(err_zero_den), 0);

    // R2 R9: ramp pattern, unit weights, isolated
    for (int k = 0; k < NSLOT; k++) begin
      for (int e = 0; e < H; e++) s[(k*H+e)*DW +: DW] = DW'(k*10 + e);
      w[k*WW +: WW] = 8'd1;
    end
    send_row(s, w, 1'b1, dummy);
    drain();

    // R2: full-scale slices, unit and full-scale weights
    s = '1; w = '0;
    for (int k = 0; k < NSLOT; k++) w[k*WW +: WW] = 8'd1;
    send_row(s, w, 1'b1, dummy);
    drain();
    w = '1;
    send_row(s, w, 1'b1, dummy);
    drain();

    // R2: denominator sweep, one non-zero weight in each slot position
    for (int k = 0; k < NSLOT; k++) begin
      for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(rnd());
      w = '0;
      w[k*WW +: WW] = WW'(k + 1);
      send_row(s, w, 1'b0, dummy);
    end
    drain();

    // R8: two rows back to back into an empty block
    for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(rnd());
    for (int k = 0; k < NSLOT; k++) w[k*WW +: WW] = WW'(rnd() % 5);
    send_row(s, w, 1'b1, acc_a);
    for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(rnd());
    send_row(s, w, 1'b0, acc_b);
    chk(acc_b < acc_a + LAT, "R8 second row accepted early", acc_b - acc_a, LAT);
    drain();

    // R7: wiggle idle inputs while the row is in flight
    for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(j * 3);
    for (int k = 0; k < NSLOT; k++) w[k*WW +: WW] = 8'd2;
    send_row(s, w, 1'b1, dummy);
    // R7
    chk(in_ready == 1'b0, "R7 in_ready low after accept", int'(in_ready), 0);
    repeat (6) begin
      @(negedge clk);
      in_slices  = {NSLOT*H*DW/32{rnd()}};
      in_weights = '1;
    end
    drain();

    // random sweep with random spacing
    for (int r = 0; r < 60; r++) begin
      for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(rnd());
      for (int k = 0; k < NSLOT; k++) w[k*WW +: WW] = WW'(rnd() % (1 + r*4));
      if (w == '0) w[0 +: WW] = 8'd1;
      send_row(s, w, 1'b0, dummy);
      repeat (rnd() % 3) @(negedge clk);
    end
    drain();

    // R5: zero denominator
    chk(err_zero_den == 1'b0, "R5 err clear before zero row", int'(err_zero_den), 0);
    for (int j = 0; j < NSLOT*H; j++) s[j*DW +: DW] = DW'(rnd() | 1);
    w = '0;
    send_row(s, w, 1'b0, dummy);
    drain();
    // R5
    chk(err_zero_den == 1'b1, "R5 err set by zero row", int'(err_zero_den), 1);

    // R6: sticky across a valid row
    for (int k = 0; k < NSLOT; k++) w[k*WW +: WW] = 8'd3;
    send_row(s, w, 1'b1, dummy);
    drain();
    // R6
    chk(err_zero_den == 1'b1, "R6 err sticky", int'(err_zero_den), 1);

    // R1: reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(err_zero_den == 1'b0, "R1 err cleared by reset", int'(err_zero_den), 0);
    chk(in_ready == 1'b1, "R1 in_ready after second reset", int'(in_ready), 1);
    chk(exp_q.size() == 0, "R2 all expected outputs seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule